// File: doc/BRIEF.md
# AXI Burst Attribute Checker

This block is a passive monitor placed beside the write-address and read-address channels of an AXI4 or AXI3 link. It only observes. Each time a request is accepted on a channel, it compares that request with the capabilities the link was built for. The capabilities are the data width, whether sub-width (narrow) transfers are allowed, the longest permitted burst, and the protocol flavour. Any request outside those limits is reported as a rule violation.

Six rules are watched: three on the write-address side and three on the read-address side. They are:
- a multi-beat burst narrower than the bus;
- a multi-beat burst whose cache attribute is not modifiable;
- a burst longer than the configured limit.

Each rule has its own one-cycle error pulse and its own sticky flag. A saturating counter totals every violation seen since reset. Integration logic or a debug view can read these outputs without touching the bus.

Top module: `axi_burst_rule_monitor`

## Requirements
- R1: With `NARROW_OK`=0, an accepted write request with effective length above zero and `aw_size` below log2(`DATA_W`/8) raises rule bit 0.
- R2: With `NARROW_OK`=0, an accepted read request with effective length above zero and `ar_size` below log2(`DATA_W`/8) raises rule bit 1.
- R3: With `NARROW_OK`=0, an accepted write request with effective length above zero and `aw_cache[1]` (modifiable) clear raises rule bit 2.
- R4: With `NARROW_OK`=0, an accepted read request with effective length above zero and `ar_cache[1]` clear raises rule bit 3.
- R5: An accepted request whose effective length (beats minus one) exceeds `MAX_LEN` raises rule bit 4 for a write and rule bit 5 for a read.
- R6: A request is judged only in a cycle where that channel's valid and ready are both high. No rule fires in any other cycle, whatever the other fields hold.
- R7: A violation shows on `err_pulse` in the cycle after the handshake, for exactly one cycle.
- R8: Each `err_sticky` bit sets when its pulse bit fires and stays set until reset.
- R9: `err_count` adds the number of pulse bits high in each cycle and saturates at all ones.
- R10: While `rst_n` is low, `err_pulse`, `err_sticky` and `err_count` are zero, and requests presented during reset are never reported.
- R11: With `NARROW_OK`=1, rule bits 0 to 3 never fire.
- R12: With `AXI3`=1, only bits [3:0] of each length port count as the effective length. With `AXI3`=0, all 8 bits count.
- R13: A single-beat request (effective length zero) never raises the narrow-size or non-modifiable rules, whatever its size and cache values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aw_valid | input | 1 | Write-address valid |
| aw_ready | input | 1 | Write-address ready |
| aw_len | input | 8 | Write burst length, beats minus one |
| aw_size | input | 3 | Write beat size, log2 of bytes |
| aw_cache | input | 4 | Write cache attributes; bit 1 is modifiable |
| ar_valid | input | 1 | Read-address valid |
| ar_ready | input | 1 | Read-address ready |
| ar_len | input | 8 | Read burst length, beats minus one |
| ar_size | input | 3 | Read beat size, log2 of bytes |
| ar_cache | input | 4 | Read cache attributes; bit 1 is modifiable |
| err_pulse | output | 6 | Per-rule one-cycle violation pulse |
| err_sticky | output | 6 | Per-rule sticky violation flag |
| err_count | output | CNT_W | Saturating total of violations |

## Verification
The assertions assume that `rst_n` is a clean level with no unknown values. They also assume that the channel inputs are stable around each rising edge, so the registered outcome of a handshake can be tied back one cycle with `$past`. The bench changes every input only on the falling edge. It holds reset low for several cycles while an illegal request is presented, which keeps the inputs inside these assumptions. Two instances with opposite flavour, narrow-support and counter-width settings are driven with the same stimulus and compared against a behavioural model.

// File: rtl/burst_mon_pkg.sv
package burst_mon_pkg;

    localparam int NUM_CHAN  = 2;             // 0 = write address, 1 = read address
    localparam int NUM_RULES = 3 * NUM_CHAN;

    // Rule bit positions: base + channel index
    localparam int NSIZE_BASE = 0;
    localparam int NCACHE_BASE = NUM_CHAN;
    localparam int MAXLEN_BASE = 2 * NUM_CHAN;

    typedef struct packed {
        logic       valid;
        logic       ready;
        logic [7:0] len;
        logic [2:0] size;
        logic [3:0] cache;
    } addr_req_t;

    typedef struct packed {
        logic max_len;
        logic non_mod;
        logic narrow;
    } chan_hits_t;

endpackage

// File: rtl/burst_chan_rules.sv
module burst_chan_rules
    import burst_mon_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter bit NARROW_OK = 1'b0,
    parameter int MAX_LEN   = 15,
    parameter bit AXI3      = 1'b0
) (
    input  addr_req_t  req,
    output chan_hits_t hits
);

    localparam int         LEN_W     = AXI3 ? 4 : 8;
    localparam logic [7:0] LEN_MASK  = 8'((1 << LEN_W) - 1);
    localparam logic [2:0] FULL_SIZE = 3'($clog2(DATA_W / 8));
    localparam logic [8:0] LEN_LIMIT = 9'(MAX_LEN);

    logic       accepted;
    logic [7:0] eff_len;
    logic       multi_beat;

    always_comb begin
        accepted   = req.valid && req.ready;
        eff_len    = req.len & LEN_MASK;
        multi_beat = (eff_len != 8'd0);

        hits.narrow  = accepted && !NARROW_OK && multi_beat && (req.size < FULL_SIZE);
        hits.non_mod = accepted && !NARROW_OK && multi_beat && !req.cache[1];
        hits.max_len = accepted && ({1'b0, eff_len} > LEN_LIMIT);
    end

endmodule

// File: rtl/burst_err_accum.sv
module burst_err_accum #(
    parameter int NUM   = 6,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM-1:0]   hit,
    output logic [NUM-1:0]   pulse,
    output logic [NUM-1:0]   sticky,
    output logic [CNT_W-1:0] count
);

    localparam int ADD_W = $clog2(NUM + 1);

    typedef struct packed {
        logic [NUM-1:0]   pulse;
        logic [NUM-1:0]   sticky;
        logic [CNT_W-1:0] count;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [ADD_W-1:0] ones_d;
    logic [CNT_W:0]   sum_d;

    always_comb begin
        ones_d = '0;
        for (int i = 0; i < NUM; i++) begin
            ones_d = ones_d + ADD_W'(hit[i]);
        end
        sum_d = {1'b0, st_q.count} + (CNT_W + 1)'(ones_d);

        st_d        = st_q;
        st_d.pulse  = hit;
        st_d.sticky = st_q.sticky | hit;
        st_d.count  = sum_d[CNT_W] ? '1 : sum_d[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse  = st_q.pulse;
    assign sticky = st_q.sticky;
    assign count  = st_q.count;

    // R8: sticky flags never clear outside reset
    a_r8_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((sticky & $past(sticky)) == $past(sticky)));

    // R8: any pulse bit is mirrored in the sticky flags
    a_r8_pulse_sets_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((sticky & pulse) == pulse));

    // R9: the total never goes down
    a_r9_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (count >= $past(count)));

    // R9: the total moves only in cycles following a detected violation
    a_r9_count_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hit) == '0) |-> (count == $past(count)));

endmodule

// File: rtl/axi_burst_rule_monitor.sv
module axi_burst_rule_monitor
    import burst_mon_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter bit NARROW_OK = 1'b0,
    parameter int MAX_LEN   = 15,
    parameter bit AXI3      = 1'b0,
    parameter int CNT_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 aw_valid,
    input  logic                 aw_ready,
    input  logic [7:0]           aw_len,
    input  logic [2:0]           aw_size,
    input  logic [3:0]           aw_cache,
    input  logic                 ar_valid,
    input  logic                 ar_ready,
    input  logic [7:0]           ar_len,
    input  logic [2:0]           ar_size,
    input  logic [3:0]           ar_cache,
    output logic [NUM_RULES-1:0] err_pulse,
    output logic [NUM_RULES-1:0] err_sticky,
    output logic [CNT_W-1:0]     err_count
);

    addr_req_t      req   [NUM_CHAN];
    chan_hits_t     hits  [NUM_CHAN];
    logic [NUM_RULES-1:0] rule_hit;

    assign req[0] = '{valid: aw_valid, ready: aw_ready, len: aw_len, size: aw_size, cache: aw_cache};
    assign req[1] = '{valid: ar_valid, ready: ar_ready, len: ar_len, size: ar_size, cache: ar_cache};

    for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
        burst_chan_rules #(
            .DATA_W    (DATA_W),
            .NARROW_OK (NARROW_OK),
            .MAX_LEN   (MAX_LEN),
            .AXI3      (AXI3)
        ) u_rules (
            .req  (req[ch]),
            .hits (hits[ch])
        );
        assign rule_hit[NSIZE_BASE  + ch] = hits[ch].narrow;
        assign rule_hit[NCACHE_BASE + ch] = hits[ch].non_mod;
        assign rule_hit[MAXLEN_BASE + ch] = hits[ch].max_len;
    end

    burst_err_accum #(
        .NUM   (NUM_RULES),
        .CNT_W (CNT_W)
    ) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (rule_hit),
        .pulse  (err_pulse),
        .sticky (err_sticky),
        .count  (err_count)
    );

    // R6: write-side rules report only after a write handshake
    a_r6_aw_needs_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse[0] || err_pulse[2] || err_pulse[4]) |-> $past(aw_valid && aw_ready));

    // R6: read-side rules report only after a read handshake
    a_r6_ar_needs_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse[1] || err_pulse[3] || err_pulse[5]) |-> $past(ar_valid && ar_ready));

    // R13: an accepted zero-length write is never called narrow or non-modifiable
    a_r13_single_beat_aw: assert property (@(posedge clk) disable iff (!rst_n)
        $past(aw_valid && aw_ready && aw_len == 8'd0) |-> !(err_pulse[0] || err_pulse[2]));

    // R13: same for reads
    a_r13_single_beat_ar: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ar_valid && ar_ready && ar_len == 8'd0) |-> !(err_pulse[1] || err_pulse[3]));

    if (NARROW_OK) begin : g_narrow_chk
        // R11: narrow-capable links never report the narrow rules
        a_r11_narrow_rules_off: assert property (@(posedge clk) disable iff (!rst_n)
            (err_pulse[3:0] == 4'b0000));
    end

endmodule

// File: tb/axi_burst_rule_monitor_tb.sv
module axi_burst_rule_monitor_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic aw_valid = 0, aw_ready = 0, ar_valid = 0, ar_ready = 0;
    logic [7:0] aw_len = 0, ar_len = 0;
    logic [2:0] aw_size = 0, ar_size = 0;
    logic [3:0] aw_cache = 0, ar_cache = 0;

    logic [5:0]  p0, s0, p1, s1;
    logic [15:0] c0;
    logic [3:0]  c1;

    int checks = 0;
    int failures = 0;
    int m_cnt [2];
    logic [5:0] m_sticky [2];
    logic [5:0] m_pulse [2];

    always #5 clk = ~clk;

    // Instance 0: AXI4, 64-bit, narrow unsupported, limit 15
    axi_burst_rule_monitor u_dut (
        .clk(clk), .rst_n(rst_n),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_len(aw_len), .aw_size(aw_size), .aw_cache(aw_cache),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_len(ar_len), .ar_size(ar_size), .ar_cache(ar_cache),
        .err_pulse(p0), .err_sticky(s0), .err_count(c0)
    );

    // Instance 1: AXI3, 32-bit, narrow supported, limit 7, 4-bit counter
    axi_burst_rule_monitor #(.DATA_W(32), .NARROW_OK(1'b1), .MAX_LEN(7), .AXI3(1'b1), .CNT_W(4)) u_dut3 (
        .clk(clk), .rst_n(rst_n),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_len(aw_len), .aw_size(aw_size), .aw_cache(aw_cache),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_len(ar_len), .ar_size(ar_size), .ar_cache(ar_cache),
        .err_pulse(p1), .err_sticky(s1), .err_count(c1)
    );

    function automatic logic [5:0] ref_hits(int full, bit nok, int maxl, bit a3);
        logic [5:0] h = '0;
        int wl = a3 ? (int'(aw_len) % 16) : int'(aw_len);
        int rl = a3 ? (int'(ar_len) % 16) : int'(ar_len);
        if (aw_valid && aw_ready) begin
            if (!nok && wl > 0 && int'(aw_size) < full) h[0] = 1'b1;
            if (!nok && wl > 0 && !aw_cache[1])         h[2] = 1'b1;
            if (wl > maxl)                              h[4] = 1'b1;
        end
        if (ar_valid && ar_ready) begin
            if (!nok && rl > 0 && int'(ar_size) < full) h[1] = 1'b1;
            if (!nok && rl > 0 && !ar_cache[1])         h[3] = 1'b1;
            if (rl > maxl)                              h[5] = 1'b1;
        end
        return h;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_update(int idx, logic [5:0] h, int cmax);
        if (!rst_n) begin
            m_pulse[idx] = '0; m_sticky[idx] = '0; m_cnt[idx] = 0;
        end else begin
            m_pulse[idx]  = h;
            m_sticky[idx] = m_sticky[idx] | h;
            m_cnt[idx]    = m_cnt[idx] + $countones(h);
            if (m_cnt[idx] > cmax) m_cnt[idx] = cmax;
        end
    endtask

    // One clock: model at the edge, compare on the following falling edge
    task automatic cycle(string tag);
        logic [5:0] h0, h1;
        @(posedge clk);
        h0 = ref_hits(3, 1'b0, 15, 1'b0);
        h1 = ref_hits(2, 1'b1, 7, 1'b1);
        model_update(0, h0, 65535);
        model_update(1, h1, 15);
        @(negedge clk);
        chk(tag, "dut0 pulse",  int'(p0), int'(m_pulse[0]));
        chk(tag, "dut0 sticky", int'(s0), int'(m_sticky[0]));
        chk(tag, "dut0 count",  int'(c0), m_cnt[0]);
        chk(tag, "dut1 pulse",  int'(p1), int'(m_pulse[1]));
        chk(tag, "dut1 sticky", int'(s1), int'(m_sticky[1]));
        chk(tag, "dut1 count",  int'(c1), m_cnt[1]);
    endtask

    task automatic set_aw(logic v, logic r, logic [7:0] l, logic [2:0] s, logic [3:0] c);
        aw_valid = v; aw_ready = r; aw_len = l; aw_size = s; aw_cache = c;
    endtask

    task automatic set_ar(logic v, logic r, logic [7:0] l, logic [2:0] s, logic [3:0] c);
        ar_valid = v; ar_ready = r; ar_len = l; ar_size = s; ar_cache = c;
    endtask

    task automatic idle();
        set_aw(0, 0, 0, 0, 0);
        set_ar(0, 0, 0, 0, 0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired before the run completed");
        summary();
    end

    initial begin
        m_cnt[0] = 0; m_cnt[1] = 0;
        m_sticky[0] = '0; m_sticky[1] = '0;
        m_pulse[0] = '0; m_pulse[1] = '0;
        @(negedge clk);
        // R10: illegal requests during reset are never reported
        set_aw(1, 1, 8'd200, 3'd0, 4'd0);
        set_ar(1, 1, 8'd200, 3'd0, 4'd0);
        repeat (3) cycle("R10");
        idle();
        rst_n = 1'b1;
        cycle("R10");

        // R1: legal full-width modifiable burst, then a narrow write burst
        set_aw(1, 1, 8'd3, 3'd3, 4'b0011); cycle("R1");
        set_aw(1, 1, 8'd3, 3'd2, 4'b0010); cycle("R1");
        // R7: the pulse lasts one cycle
        idle(); cycle("R7");
        // R2: narrow read burst (R11 on the narrow-capable instance)
        set_ar(1, 1, 8'd1, 3'd1, 4'b1111); cycle("R2");
        idle(); cycle("R11");
        // R3: non-modifiable multi-beat write
        set_aw(1, 1, 8'd1, 3'd3, 4'b1101); cycle("R3");
        idle();
        // R4: non-modifiable multi-beat read
        set_ar(1, 1, 8'd7, 3'd3, 4'b0001); cycle("R4");
        idle();
        // R5 and R12: length 16 is over the AXI4 limit, is 0 on the AXI3 instance
        set_aw(1, 1, 8'd16, 3'd3, 4'b0010); cycle("R12");
        // R5: length 8 breaks only the limit of 7
        set_aw(1, 1, 8'd8, 3'd3, 4'b0010); cycle("R5");
        set_ar(1, 1, 8'd15, 3'd3, 4'b0010); idle(); set_ar(1, 1, 8'd15, 3'd3, 4'b0010); cycle("R5");
        set_ar(1, 1, 8'd16, 3'd3, 4'b0010); cycle("R5");
        idle();
        // R6: valid without ready, ready without valid
        set_aw(1, 0, 8'd255, 3'd0, 4'd0); set_ar(0, 1, 8'd255, 3'd0, 4'd0); cycle("R6");
        set_aw(0, 1, 8'd255, 3'd0, 4'd0); set_ar(1, 0, 8'd255, 3'd0, 4'd0); cycle("R6");
        // R13: single-beat requests with small size and non-modifiable cache
        set_aw(1, 1, 8'd0, 3'd0, 4'd0); set_ar(1, 1, 8'd0, 3'd0, 4'd0); cycle("R13");
        // R12: AXI3 instance sees 0x10 as single beat on both channels
        set_aw(1, 1, 8'h10, 3'd0, 4'd0); set_ar(1, 1, 8'h10, 3'd0, 4'd0); cycle("R12");
        // R9: several rules at once on both channels
        set_aw(1, 1, 8'd31, 3'd0, 4'd0); set_ar(1, 1, 8'd31, 3'd1, 4'd0); cycle("R9");
        // R9: drive the 4-bit counter into saturation
        for (int i = 0; i < 10; i++) begin
            set_aw(1, 1, 8'd15, 3'd3, 4'b0010); set_ar(1, 1, 8'd14, 3'd3, 4'b0010);
            cycle("R9");
        end
        idle(); cycle("R8");
        // R10: mid-run reset clears everything
        @(negedge clk); rst_n = 1'b0;
        cycle("R10");
        rst_n = 1'b1;
        cycle("R10");
        set_aw(1, 1, 8'd2, 3'd2, 4'b0010); cycle("R1");
        idle(); cycle("R8");
        summary();
    end

endmodule